// File: doc/BRIEF.md
# Three-Wire Configuration Register Write Port

This block is a write-only serial slave that loads a bank of 24-bit configuration registers from three wires: a serial clock, a serial data line and an active-low load strobe. While the load strobe is low, bits are taken on each rising serial-clock edge. The first eight bits form a start address. Every following group of twenty-four bits forms one data word, and the address moves up by one after each word. All fields arrive least significant bit first. The serial wires are slow compared with the system clock. They pass through two-flop synchronizers, and the block does all its edge detection in the system clock domain.

Written values first land in a shadow bank. On each falling edge of an active-low frame sync input, the shadow bank is copied into the live bank that drives the rest of the chip. Setting an update-hold register suspends this copy, so software can stage a complete configuration and release it at one sync edge. A chosen set of registers is updated immediately instead: the hold register, the soft-reset register and any others named by a parameter mask. Writing 1 to the soft-reset register returns both banks to their defaults.

Top module: `tw_cfg_port`

## Requirements
- R1: A frame carries an 8-bit address and then 24-bit data words. Both fields are sent LSB first, and each bit is taken on a rising serial-clock edge while the load strobe is low. A complete word is stored at its address.
- R2: A word cut short because the load strobe rises before its 24th bit is discarded. The targeted register keeps its value, and the complete words before it in the same frame are still stored.
- R3: Each further word in a frame goes to the previous address plus one. The address wraps from 0xFF to 0x00.
- R4: Writes to addresses at or above NUM_REGS (default 16) have no effect on any register.
- R5: Registers 0 and 1 hold 1 bit. Registers flagged in NARROW_MASK (default 4 to 7) hold NARROW_W bits (default 16). All others hold 24 bits. Data bits above a register's width are dropped and always read 0.
- R6: A write to a register that is not immediate changes only its shadow. The live value on cfg_live_o changes on the first falling edge of sync_n_i after the write.
- R7: While bit 0 of register 1 (update hold) is 1, a falling sync edge copies nothing. After the hold is cleared, the next falling sync edge copies the whole shadow bank. A rising sync edge never copies.
- R8: Registers 0, 1 and those flagged in IMMED_MASK (default register 3) update their live value directly when written, with no sync edge needed.
- R9: Writing a word with bit 0 set to register 0 returns every shadow and live register to its default. Register 0 always reads 0.
- R10: After reset, register i holds (0x5A0000 + 0x111*i) truncated to its width, and registers 0 and 1 hold 0.
- R11: Serial-clock edges while the load strobe is high have no effect. Each fall of the strobe starts a new frame at its address field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial clock; data taken on its rising edge |
| ser_dat_i | input | 1 | Serial data, LSB first |
| ser_ld_n_i | input | 1 | Active-low frame load strobe |
| sync_n_i | input | 1 | Active-low frame/line sync; falling edge commits shadow values |
| cfg_live_o | output | NUM_REGS*24 | Live register bank, register i at bits [24*i+23:24*i] |

## Verification
The bench goes after these corner cases:
- **Address wrap.** A frame starts at 0xFE and runs across 0x00. A counter that saturates, or that decodes beyond 8 bits, would leave register 2 untouched or store to a wrong register.
- **Early strobe release.** A frame ends after ten bits of its second word. A design that flushed partial words would corrupt the next register.
- **Hold sequence.** A write is staged under hold, then passed over by a falling sync edge, a rising sync edge and the release of the hold. A commit that ignored the hold or fired on the wrong edge would show the new value too early.
- **Soft reset.** A soft reset is issued while a shadow value is pending. A design that cleared only the live bank would let the pending value escape at the next sync.

// File: rtl/tw_cfg_pkg.sv
package tw_cfg_pkg;

    localparam int ADDR_W = 8;
    localparam int WORD_W = 24;
    localparam int CNT_W  = $clog2(WORD_W);

    // fixed control register locations
    localparam int SRST_IDX = 0;
    localparam int HOLD_IDX = 1;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic              sclk_prev;
        logic              in_data;
        logic [CNT_W-1:0]  cnt;
        addr_t             addr;
        word_t             shreg;
        logic              wr_en;
        addr_t             wr_addr;
        word_t             wr_data;
    } deser_st_t;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q, meta_d;
    logic [W-1:0] stab_q, stab_d;

    always_comb begin
        meta_d = async_i;
        stab_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= meta_d;
            stab_q <= stab_d;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/tw_deser.sv
module tw_deser
    import tw_cfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sclk_s,
    input  logic  sdat_s,
    input  logic  ld_n_s,
    output logic  wr_en_o,
    output addr_t wr_addr_o,
    output word_t wr_data_o
);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_W - 1);

    deser_st_t st_q, st_d;
    logic      sclk_rise;

    always_comb begin
        st_d           = st_q;
        st_d.wr_en     = 1'b0;
        st_d.sclk_prev = sclk_s;
        sclk_rise      = sclk_s && !st_q.sclk_prev;

        if (ld_n_s) begin
            // outside a frame: drop any partial field
            st_d.in_data = 1'b0;
            st_d.cnt     = '0;
        end else if (sclk_rise) begin
            if (!st_q.in_data) begin
                st_d.addr = {sdat_s, st_q.addr[ADDR_W-1:1]};
                if (st_q.cnt == ADDR_LAST) begin
                    st_d.in_data = 1'b1;
                    st_d.cnt     = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                st_d.shreg = {sdat_s, st_q.shreg[WORD_W-1:1]};
                if (st_q.cnt == WORD_LAST) begin
                    st_d.wr_en   = 1'b1;
                    st_d.wr_addr = st_q.addr;
                    st_d.wr_data = {sdat_s, st_q.shreg[WORD_W-1:1]};
                    st_d.addr    = st_q.addr + 1'b1;
                    st_d.cnt     = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en_o   = st_q.wr_en;
    assign wr_addr_o = st_q.wr_addr;
    assign wr_data_o = st_q.wr_data;
endmodule

// File: rtl/tw_regbank.sv
module tw_regbank
    import tw_cfg_pkg::*;
#(
    parameter int                   NUM_REGS    = 16,
    parameter int                   NARROW_W    = 16,
    parameter logic [NUM_REGS-1:0]  IMMED_MASK  = NUM_REGS'('h8),
    parameter logic [NUM_REGS-1:0]  NARROW_MASK = NUM_REGS'('hF0)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  addr_t                      wr_addr_i,
    input  word_t                      wr_data_i,
    input  logic                       sync_s,
    output logic                       commit_o,
    output logic                       hold_o,
    output logic [NUM_REGS*WORD_W-1:0] live_o,
    output logic [NUM_REGS*WORD_W-1:0] dflt_o
);
    localparam logic [NUM_REGS-1:0] IMM_ALL =
        IMMED_MASK | NUM_REGS'((1 << SRST_IDX) | (1 << HOLD_IDX));

    typedef logic [NUM_REGS-1:0][WORD_W-1:0] bank_t;

    typedef struct packed {
        bank_t shadow;
        bank_t live;
        logic  sync_prev;
    } bank_st_t;

    bank_t    wmask;
    bank_t    dflt;
    bank_st_t bk_q, bk_d;
    logic     commit;

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        if (gi == SRST_IDX || gi == HOLD_IDX) begin : g_ctl
            assign wmask[gi] = word_t'(1);
            assign dflt[gi]  = '0;
        end else if (NARROW_MASK[gi]) begin : g_nar
            assign wmask[gi] = word_t'((1 << NARROW_W) - 1);
            assign dflt[gi]  = word_t'(24'h5A0000 + 24'h000111 * gi) & wmask[gi];
        end else begin : g_full
            assign wmask[gi] = '1;
            assign dflt[gi]  = word_t'(24'h5A0000 + 24'h000111 * gi);
        end
    end

    always_comb begin
        bk_d           = bk_q;
        bk_d.sync_prev = sync_s;
        commit         = bk_q.sync_prev && !sync_s && !bk_q.live[HOLD_IDX][0];

        if (commit) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (!IMM_ALL[i]) begin
                    bk_d.live[i] = bk_q.shadow[i];
                end
            end
        end

        if (wr_en_i) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_addr_i == ADDR_W'(i)) begin
                    if (i == SRST_IDX) begin
                        if (wr_data_i[0]) begin
                            bk_d.shadow = dflt;
                            bk_d.live   = dflt;
                        end
                    end else begin
                        bk_d.shadow[i] = wr_data_i & wmask[i];
                        if (IMM_ALL[i]) begin
                            bk_d.live[i] = wr_data_i & wmask[i];
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q.shadow    <= dflt;
            bk_q.live      <= dflt;
            bk_q.sync_prev <= 1'b1;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign commit_o = commit;
    assign hold_o   = bk_q.live[HOLD_IDX][0];
    assign live_o   = bk_q.live;
    assign dflt_o   = dflt;
endmodule

// File: rtl/tw_cfg_port.sv
module tw_cfg_port
    import tw_cfg_pkg::*;
#(
    parameter int                   NUM_REGS    = 16,
    parameter int                   NARROW_W    = 16,
    parameter logic [NUM_REGS-1:0]  IMMED_MASK  = NUM_REGS'('h8),
    parameter logic [NUM_REGS-1:0]  NARROW_MASK = NUM_REGS'('hF0)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ser_clk_i,
    input  logic                       ser_dat_i,
    input  logic                       ser_ld_n_i,
    input  logic                       sync_n_i,
    output logic [NUM_REGS*WORD_W-1:0] cfg_live_o
);
    logic                       sclk_s, sdat_s, ld_n_s, sync_s;
    logic                       wr_en;
    addr_t                      wr_addr;
    word_t                      wr_data;
    logic                       commit;
    logic                       hold;
    logic [NUM_REGS*WORD_W-1:0] dflt_flat;

    // idle levels: clock low, data low, load high, sync high
    tw_sync #(.W(4), .RST_VAL(4'b0011)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_clk_i, ser_dat_i, ser_ld_n_i, sync_n_i}),
        .sync_o  ({sclk_s, sdat_s, ld_n_s, sync_s})
    );

    tw_deser u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sclk_s),
        .sdat_s    (sdat_s),
        .ld_n_s    (ld_n_s),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data)
    );

    tw_regbank #(
        .NUM_REGS    (NUM_REGS),
        .NARROW_W    (NARROW_W),
        .IMMED_MASK  (IMMED_MASK),
        .NARROW_MASK (NARROW_MASK)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .sync_s    (sync_s),
        .commit_o  (commit),
        .hold_o    (hold),
        .live_o    (cfg_live_o),
        .dflt_o    (dflt_flat)
    );
endmodule

// File: rtl/tw_cfg_port_chk.sv
module tw_cfg_port_chk #(
    parameter int                  NUM_REGS    = 16,
    parameter int                  NARROW_W    = 16,
    parameter logic [NUM_REGS-1:0] NARROW_MASK = NUM_REGS'('hF0)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [7:0]               wr_addr,
    input logic [23:0]              wr_data,
    input logic                     commit,
    input logic                     hold,
    input logic                     ld_n_s,
    input logic                     sync_s,
    input logic [NUM_REGS*24-1:0]   cfg_live_o,
    input logic [NUM_REGS*24-1:0]   dflt_flat
);
    logic       sync_prev_q;
    logic       seen_wr_q;
    logic [7:0] last_addr_q;
    logic       sync_fall;

    assign sync_fall = sync_prev_q && !sync_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_prev_q <= 1'b1;
            seen_wr_q   <= 1'b0;
            last_addr_q <= '0;
        end else begin
            sync_prev_q <= sync_s;
            if (ld_n_s) begin
                seen_wr_q <= 1'b0;
            end else if (wr_en) begin
                seen_wr_q   <= 1'b1;
                last_addr_q <= wr_addr;
            end
        end
    end

    // R9
    srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 8'd0 && wr_data[0]) |=> (cfg_live_o == dflt_flat));

    // R6
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !commit) |=> $stable(cfg_live_o));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_fall && hold && !wr_en) |=> $stable(cfg_live_o));

    // R11
    in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !ld_n_s);

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && seen_wr_q) |-> (wr_addr == last_addr_q + 8'd1));

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_nar
        if (NARROW_MASK[gi] && gi > 1) begin : g_on
            // R5
            narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cfg_live_o[gi*24+NARROW_W +: 24-NARROW_W] == '0);
        end
    end
endmodule

bind tw_cfg_port tw_cfg_port_chk #(
    .NUM_REGS    (NUM_REGS),
    .NARROW_W    (NARROW_W),
    .NARROW_MASK (NARROW_MASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .commit     (commit),
    .hold       (hold),
    .ld_n_s     (ld_n_s),
    .sync_s     (sync_s),
    .cfg_live_o (cfg_live_o),
    .dflt_flat  (dflt_flat)
);

// File: tb/tw_cfg_port_tb.sv
module tw_cfg_port_tb;
    localparam int N = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdat = 1'b0, ld_n = 1'b1, sync_n = 1'b1;
    logic [N*24-1:0] live;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;
    string tag = "R10";

    int shadow_m [N];
    int live_m   [N];

    always #4 clk = ~clk;

    tw_cfg_port u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk_i  (sclk),
        .ser_dat_i  (sdat),
        .ser_ld_n_i (ld_n),
        .sync_n_i   (sync_n),
        .cfg_live_o (live)
    );

    // widths from R5, defaults from R10, immediate set from R8
    function automatic int mask_of(int i);
        if (i < 2) return 1;
        if (i >= 4 && i <= 7) return 'hFFFF;
        return 'hFFFFFF;
    endfunction

    function automatic int dflt_of(int i);
        if (i < 2) return 0;
        return ('h5A0000 + 'h111 * i) & mask_of(i);
    endfunction

    function automatic bit immed(int i);
        return (i == 0 || i == 1 || i == 3);
    endfunction

    function automatic int live_of(int i);
        return int'(live[i*24 +: 24]);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            shadow_m[i] = dflt_of(i);
            live_m[i]   = dflt_of(i);
        end
    endtask

    task automatic model_write(int a, int d);
        int v;
        if (a >= N) return;
        v = d & mask_of(a);
        if (a == 0) begin
            if (v[0]) model_reset();
        end else begin
            shadow_m[a] = v;
            if (immed(a)) live_m[a] = v;
        end
    endtask

    task automatic model_commit();
        if ((live_m[1] & 1) == 0)
            for (int i = 0; i < N; i++)
                if (!immed(i)) live_m[i] = shadow_m[i];
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            checks++;
            for (int i = 0; i < N; i++) begin
                if (live_of(i) != live_m[i]) begin
                    errors++;
                    $display("FAIL %s: reg %0d actual %h expected %h", tag, i, live_of(i), live_m[i]);
                    break;
                end
            end
        end
    end

    task automatic check_reg(int i, int exp, string t);
        @(negedge clk);
        checks++;
        if (live_of(i) != exp) begin
            errors++;
            $display("FAIL %s: reg %0d actual %h expected %h", t, i, live_of(i), exp);
        end
    endtask

    task automatic send_bit(bit b);
        sdat = b;
        repeat (4) @(posedge clk);
        sclk = 1'b1;
        repeat (4) @(posedge clk);
        sclk = 1'b0;
    endtask

    // frame: address, full words, then tail_bits of an extra word
    task automatic frame(int a, int words[$], int tail_bits = 0, int tail = 0);
        cmp_en = 1'b0;
        ld_n = 1'b0;
        repeat (4) @(posedge clk);
        for (int b = 0; b < 8; b++) send_bit(a[b]);
        foreach (words[k])
            for (int b = 0; b < 24; b++) send_bit(words[k][b]);
        for (int b = 0; b < tail_bits; b++) send_bit(tail[b]);
        repeat (4) @(posedge clk);
        ld_n = 1'b1;
        repeat (10) @(posedge clk);
        foreach (words[k]) model_write((a + k) & 'hFF, words[k]);
        cmp_en = 1'b1;
    endtask

    task automatic pulse_sync();
        cmp_en = 1'b0;
        sync_n = 1'b0;
        repeat (8) @(posedge clk);
        model_commit();
        sync_n = 1'b1;
        repeat (8) @(posedge clk);
        cmp_en = 1'b1;
    endtask

    initial begin
        model_reset();
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);

        tag = "R10";
        cmp_en = 1'b1;
        for (int i = 0; i < N; i++) check_reg(i, dflt_of(i), "R10");

        tag = "R6";
        frame(8, '{'hABCDEF});
        check_reg(8, dflt_of(8), "R6");
        tag = "R1";
        pulse_sync();
        check_reg(8, 'hABCDEF, "R1");

        tag = "R8";
        frame(3, '{'h123456});
        check_reg(3, 'h123456, "R8");

        tag = "R5";
        frame(5, '{'hFFFFFF});
        pulse_sync();
        check_reg(5, 'h00FFFF, "R5");
        frame(1, '{'hFFFFFE});
        check_reg(1, 0, "R5");

        tag = "R3";
        frame(9, '{'h111111, 'h222222, 'h333333});
        pulse_sync();
        check_reg(9, 'h111111, "R3");
        check_reg(11, 'h333333, "R3");

        tag = "R4";
        frame('hFE, '{'h0F0F0F, 'hF0F0F0, 0, 0, 'h777777});
        pulse_sync();
        check_reg(2, 'h777777, "R3");
        check_reg(14, dflt_of(14), "R4");

        tag = "R2";
        frame(12, '{'hC0FFEE}, 10, 'h3FF);
        pulse_sync();
        check_reg(12, 'hC0FFEE, "R2");
        check_reg(13, dflt_of(13), "R2");

        tag = "R7";
        frame(1, '{1});
        frame(10, '{'h0A0A0A});
        pulse_sync();
        check_reg(10, 'h222222, "R7");
        frame(1, '{0});
        check_reg(10, 'h222222, "R7");
        pulse_sync();
        check_reg(10, 'h0A0A0A, "R7");

        tag = "R9";
        frame(15, '{'h999999});
        frame(0, '{1});
        check_reg(8, dflt_of(8), "R9");
        check_reg(0, 0, "R9");
        pulse_sync();
        check_reg(15, dflt_of(15), "R9");

        tag = "R11";
        for (int k = 0; k < 40; k++) send_bit(k[0]);
        repeat (10) @(posedge clk);
        check_reg(3, dflt_of(3), "R11");
        frame(3, '{'h654321});
        check_reg(3, 'h654321, "R11");

        repeat (5) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule